// File: doc/BRIEF.md
# Serial Management Register Port

This block gives a MAC access to a PHY's 256-entry, 8-bit register space over one shared serial wire. The wire idles high. The MAC opens a frame with a low start bit, then sends a direction bit and an 8-bit address. For a write, the MAC keeps the wire and shifts in eight data bits. For a read, the wire goes undriven for one turnaround cycle. The block then drives the eight register bits back and releases the wire in the following cycle. Both sides sample the wire on the rising clock edge.

The address space has three regions. The lowest thirty-two addresses are dynamic read/write registers, some of which have reserved bits. The next region holds read-only constants that describe the PHY. The upper half is left to the vendor and is not populated here. One dynamic register is the clear-channel-assessment request. Writing it emits a one-cycle start pulse toward the radio and clears a separate status line. A stub measurement input then supplies the result, and the status line holds that result until the next request.

The wire is split into an input, an output and an output enable. Pad logic outside the block merges them onto one bidirectional pin, with a pull-up that keeps the idle level high.

Top module: `smi_port`

## Requirements
- R1: After reset, `ser_oe`, `cca_start` and `cca_status` are low, and every dynamic register reads 00h.
- R2: A frame is a start bit of 0, one direction bit (1 = read, 0 = write) and eight address bits, msb first. For a write, eight data bits follow, msb first. For a read, one turnaround cycle follows, then eight data bits driven by the block, msb first. While the wire stays high, no frame begins.
- R3: A write to any address 00h–0Fh stores the whole byte, and a later read of that address returns it.
- R4: Addresses 10h–17h and 19h–1Fh keep only bits 3:0 of a written byte. The request register 18h keeps only bit 0. All other bits read back as 0.
- R5: Addresses 20h–7Fh are read-only. Address 20h returns the channel map parameter with bits 7:6 forced to 0. Address 21h returns the transmit-power-level count in bits 3:0 (0 means one fixed level), with bits 7:4 zero. All other addresses in this range read 00h. Writes to the range are accepted on the wire but change nothing.
- R6: Addresses 80h–FFh read 00h. Writes there change no register, including the dynamic register that shares the same low address bits.
- R7: `ser_oe` is low during the turnaround cycle, stays high for exactly the eight read data bits, and falls in the cycle after the last data bit. It is never high during a write frame or while idle.
- R8: A write to 18h raises `cca_start` for exactly one cycle, in the cycle after the last data bit is sampled. In that same cycle `cca_status` is low.
- R9: After a request, `cca_status` stays low until the first `cca_meas_done` pulse. It then takes the value of `cca_meas_clear` and holds it until the next request. A `cca_meas_done` pulse with no request outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Level of the shared serial wire as seen by the block |
| ser_out | output | 1 | Value the block drives onto the wire during read data |
| ser_oe | output | 1 | High while the block drives the wire |
| cca_meas_done | input | 1 | One-cycle pulse from the radio stub: measurement finished |
| cca_meas_clear | input | 1 | Measurement result, sampled when `cca_meas_done` is high |
| cca_start | output | 1 | One-cycle pulse that starts a channel assessment |
| cca_status | output | 1 | Active-high assessment result, low while a request is pending |

## Verification
The bench targets the edge of the bus handover. It checks the enable during the turnaround cycle and one cycle after the last read bit. A design that drives one cycle early would clash with the MAC, and one that releases late would collide with the next start bit. It writes through addresses that share their low bits with live dynamic registers, in both the constant and vendor regions. An address decoder that compares only the index bits would corrupt those registers. It writes all-ones to registers with reserved bits and expects the masked value back. It pulses the measurement input with no request outstanding, which a design without a pending flag would wrongly latch onto the status line.

// File: rtl/smi_pkg.sv
// smi_pkg
// Shared constants, types and address-decode helpers for the serial
// management port. Assumes an 8-bit address and 8-bit data space.
package smi_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    // Region boundaries of the register space.
    localparam addr_t STATIC_BASE  = 8'h20;
    localparam addr_t VENDOR_BASE  = 8'h80;
    // Dynamic registers at or above this address keep a nibble only.
    localparam addr_t NIBBLE_BASE  = 8'h10;
    // Register whose write launches a channel assessment.
    localparam addr_t CCA_REQ_ADDR = 8'h18;

    // Constant-region locations.
    localparam addr_t CHAN_MAP_ADDR = 8'h20;
    localparam addr_t TX_LVL_ADDR   = 8'h21;
    localparam byte_t CHAN_VALID    = 8'h3F;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_CTRL,
        FS_ADDR,
        FS_TURN,
        FS_RDATA,
        FS_WDATA
    } fstate_e;

    typedef enum logic [1:0] {
        RG_DYN,
        RG_CONST,
        RG_VENDOR
    } region_e;

    // Classify an address into its region.
    function automatic region_e region_of(input addr_t a);
        if (a < STATIC_BASE)      return RG_DYN;
        else if (a < VENDOR_BASE) return RG_CONST;
        else                      return RG_VENDOR;
    endfunction

    // Writable-bit mask of a dynamic register.
    function automatic byte_t dyn_mask(input addr_t a);
        if (a == CCA_REQ_ADDR)     return 8'h01;
        else if (a >= NIBBLE_BASE) return 8'h0F;
        else                       return 8'hFF;
    endfunction

endpackage

// File: rtl/smi_frame.sv
// smi_frame
// Serial frame engine. Decodes start, direction and address bits from the
// wire, collects write data or shifts read data out, and owns the output
// enable of the shared wire. Assumes the wire idles high (external pull-up)
// and that read data for the decoded address is valid combinationally.
module smi_frame
    import smi_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] reg_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          ser_out,
    output logic          ser_oe
);

    localparam int unsigned SEQ_MAX = (AW > DW) ? AW : DW;
    localparam int unsigned CNT_W   = $clog2(SEQ_MAX);
    localparam logic [CNT_W-1:0] A_LAST = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DW - 1);

    fstate_e          state;
    logic             is_rd;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    shreg;
    logic [CNT_W-1:0] cnt;

    // Write strobe fires while the final data bit is on the wire.
    assign wr_en    = (state == FS_WDATA) && (cnt == D_LAST);
    assign wr_data  = {shreg[DW-2:0], ser_in};
    assign reg_addr = addr_q;

    // Frame sequencer: phase tracking, shifting and wire ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FS_IDLE;
            is_rd   <= 1'b0;
            addr_q  <= '0;
            shreg   <= '0;
            cnt     <= '0;
            ser_out <= 1'b1;
            ser_oe  <= 1'b0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (!ser_in) state <= FS_CTRL;
                end
                FS_CTRL: begin
                    is_rd <= ser_in;
                    cnt   <= '0;
                    state <= FS_ADDR;
                end
                FS_ADDR: begin
                    addr_q <= {addr_q[AW-2:0], ser_in};
                    if (cnt == A_LAST) begin
                        cnt   <= '0;
                        state <= is_rd ? FS_TURN : FS_WDATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                FS_TURN: begin
                    ser_out <= rd_data[DW-1];
                    shreg   <= {rd_data[DW-2:0], 1'b0};
                    ser_oe  <= 1'b1;
                    cnt     <= '0;
                    state   <= FS_RDATA;
                end
                FS_RDATA: begin
                    if (cnt == D_LAST) begin
                        ser_oe  <= 1'b0;
                        ser_out <= 1'b1;
                        state   <= FS_IDLE;
                    end else begin
                        ser_out <= shreg[DW-1];
                        shreg   <= {shreg[DW-2:0], 1'b0};
                        cnt     <= cnt + 1'b1;
                    end
                end
                FS_WDATA: begin
                    shreg <= {shreg[DW-2:0], ser_in};
                    if (cnt == D_LAST) begin
                        cnt   <= '0;
                        state <= FS_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/smi_regbank.sv
// smi_regbank
// Register space behind the serial port: masked dynamic registers,
// parameter-derived read-only constants and an empty vendor region.
// Assumes one write strobe per frame and a combinational read path.
module smi_regbank
    import smi_pkg::*;
#(
    parameter byte_t      CHAN_MAP       = 8'hC7,
    parameter logic [3:0] TX_LEVEL_COUNT = 4'd9
) (
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t reg_addr,
    input  logic  wr_en,
    input  byte_t wr_data,
    output byte_t rd_data
);

    localparam int unsigned DYN_DEPTH = int'(STATIC_BASE);
    localparam int unsigned IDX_W     = $clog2(DYN_DEPTH);

    byte_t                dyn_q [DYN_DEPTH];
    logic [DYN_DEPTH-1:0] hit;

    // Per-entry full-address match, so aliases in other regions miss.
    for (genvar g = 0; g < DYN_DEPTH; g++) begin : g_hit
        assign hit[g] = wr_en && (reg_addr == addr_t'(g));
    end

    // Dynamic storage: masked update of the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DYN_DEPTH; i++) dyn_q[i] <= '0;
        end else begin
            for (int i = 0; i < DYN_DEPTH; i++) begin
                if (hit[i]) dyn_q[i] <= wr_data & dyn_mask(addr_t'(i));
            end
        end
    end

    // Constant region contents, derived from the parameters.
    function automatic byte_t const_byte(input addr_t a);
        if (a == CHAN_MAP_ADDR)    return CHAN_MAP & CHAN_VALID;
        else if (a == TX_LVL_ADDR) return {4'b0000, TX_LEVEL_COUNT};
        else                       return '0;
    endfunction

    // Read multiplexer by region.
    always_comb begin
        case (region_of(reg_addr))
            RG_DYN:   rd_data = dyn_q[reg_addr[IDX_W-1:0]];
            RG_CONST: rd_data = const_byte(reg_addr);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/smi_cca.sv
// smi_cca
// Channel-assessment request tracker. A write to the request register
// pulses the start output and clears the status; the first measurement
// pulse afterwards loads the result. Assumes the radio stub answers with
// a one-cycle done pulse.
module smi_cca
    import smi_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  addr_t reg_addr,
    input  logic  meas_done,
    input  logic  meas_clear,
    output logic  cca_start,
    output logic  cca_status
);

    logic pending;

    // Request launch and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cca_start  <= 1'b0;
            cca_status <= 1'b0;
            pending    <= 1'b0;
        end else begin
            cca_start <= 1'b0;
            if (wr_en && (reg_addr == CCA_REQ_ADDR)) begin
                cca_start  <= 1'b1;
                cca_status <= 1'b0;
                pending    <= 1'b1;
            end else if (pending && meas_done) begin
                cca_status <= meas_clear;
                pending    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/smi_port.sv
// smi_port
// Top of the serial management register port: frame engine, register
// space and assessment tracker. The shared wire is presented as separate
// in, out and enable; pad logic merges them and provides the pull-up.
module smi_port
    import smi_pkg::*;
#(
    parameter byte_t      CHAN_MAP       = 8'hC7,
    parameter logic [3:0] TX_LEVEL_COUNT = 4'd9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic ser_out,
    output logic ser_oe,
    input  logic cca_meas_done,
    input  logic cca_meas_clear,
    output logic cca_start,
    output logic cca_status
);

    addr_t reg_addr;
    logic  wr_en;
    byte_t wr_data;
    byte_t rd_data;

    smi_frame #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ser_out  (ser_out),
        .ser_oe   (ser_oe)
    );

    smi_regbank #(
        .CHAN_MAP       (CHAN_MAP),
        .TX_LEVEL_COUNT (TX_LEVEL_COUNT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    smi_cca u_cca (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_addr   (reg_addr),
        .meas_done  (cca_meas_done),
        .meas_clear (cca_meas_clear),
        .cca_start  (cca_start),
        .cca_status (cca_status)
    );

endmodule

// File: rtl/smi_port_chk.sv
// smi_port_chk
// Protocol checker for smi_port, attached by bind. Watches the wire
// enable window and the assessment start/status handshake at the ports.
module smi_port_chk #(
    parameter int unsigned DW = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ser_oe,
    input logic cca_start,
    input logic cca_status,
    input logic cca_meas_done
);

    localparam int unsigned RUN_W = $clog2(DW + 2);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(DW);

    logic [RUN_W-1:0] oe_run;

    // Counts consecutive cycles with the wire enable high.
    always_ff @(posedge clk) begin
        if (!rst_n)      oe_run <= '0;
        else if (ser_oe) oe_run <= oe_run + 1'b1;
        else             oe_run <= '0;
    end

    // R7
    oe_window_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |-> (oe_run < RUN_FULL));

    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_oe) |-> (oe_run == RUN_FULL));

    // R8
    cca_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cca_start |=> !cca_start);

    // R8
    cca_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cca_start) |-> !cca_status);

    // R9
    cca_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cca_status) |-> (cca_start || $past(cca_meas_done)));

endmodule

bind smi_port smi_port_chk #(.DW(8)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_oe        (ser_oe),
    .cca_start     (cca_start),
    .cca_status    (cca_status),
    .cca_meas_done (cca_meas_done)
);

// File: tb/smi_port_tb.sv
// smi_port_tb
// Scoreboard bench: the read driver queues expected bytes, and a monitor
// assembles bytes from the wire and compares them in order.
module smi_port_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b1;
    logic ser_out, ser_oe;
    logic cca_meas_done = 1'b0;
    logic cca_meas_clear = 1'b0;
    logic cca_start, cca_status;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         bitn = 0;
    logic [7:0] got = '0;
    logic       start_seen, stat_seen, start_after;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_port #(
        .CHAN_MAP       (8'hC7),
        .TX_LEVEL_COUNT (4'd9)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ser_in         (ser_in),
        .ser_out        (ser_out),
        .ser_oe         (ser_oe),
        .cca_meas_done  (cca_meas_done),
        .cca_meas_clear (cca_meas_clear),
        .cca_start      (cca_start),
        .cca_status     (cca_status)
    );

    function automatic void chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // Monitor: collects driven bits and compares against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && ser_oe) begin
            got = {got[6:0], ser_out};
            bitn++;
            if (bitn == 8) begin
                bitn = 0;
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected drive", got, 8'hxx);
                end else begin
                    chk(tag_q.pop_front(), got, exp_q.pop_front());
                end
            end
        end
    end

    task automatic send_bit(input logic b);
        ser_in = b;
        @(negedge clk);
    endtask

    // Read frame; expected byte goes to the scoreboard, enable window checked here.
    task automatic do_read(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
        ser_in = 1'b1;
        chk("R7 turnaround undriven", {7'b0, ser_oe}, 8'h00);
        repeat (9) @(negedge clk);
        chk("R7 released after last bit", {7'b0, ser_oe}, 8'h00);
    endtask

    // Write frame; samples the assessment outputs around the commit cycle.
    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        send_bit(1'b0);
        send_bit(1'b0);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
        for (int i = 7; i >= 0; i--) begin
            send_bit(d[i]);
            if (ser_oe) chk("R7 driven during write", 8'h01, 8'h00);
        end
        start_seen = cca_start;
        stat_seen  = cca_status;
        ser_in = 1'b1;
        @(negedge clk);
        start_after = cca_start;
    endtask

    task automatic meas(input logic clr);
        cca_meas_clear = clr;
        cca_meas_done  = 1'b1;
        @(negedge clk);
        cca_meas_done  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 oe after reset", {7'b0, ser_oe}, 8'h00);
        chk("R1 start after reset", {7'b0, cca_start}, 8'h00);
        chk("R1 status after reset", {7'b0, cca_status}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(8'h00, 8'h00, "R1 dyn 00 reset");
        do_read(8'h18, 8'h00, "R1 dyn 18 reset");

        // R2 idle-high line starts nothing
        repeat (20) begin
            @(negedge clk);
            if (ser_oe) chk("R2 idle drive", 8'h01, 8'h00);
        end
        chk("R2 idle oe", {7'b0, ser_oe}, 8'h00);

        // R2 bit order and R3 full-byte storage
        do_write(8'h01, 8'h80);
        do_write(8'h02, 8'h01);
        do_read(8'h01, 8'h80, "R2 msb first");
        do_read(8'h02, 8'h01, "R2 lsb last");
        do_write(8'h05, 8'hA5);
        do_read(8'h05, 8'hA5, "R3 addr 05");
        do_write(8'h0F, 8'h3C);
        do_read(8'h0F, 8'h3C, "R3 addr 0F");

        // R4 reserved bits
        do_write(8'h12, 8'hFF);
        do_read(8'h12, 8'h0F, "R4 addr 12 nibble");
        do_write(8'h1F, 8'hA5);
        do_read(8'h1F, 8'h05, "R4 addr 1F nibble");

        // R8 request launch, R4 request register mask
        do_write(8'h18, 8'hFE);
        chk("R8 start pulse", {7'b0, start_seen}, 8'h01);
        chk("R8 status cleared", {7'b0, stat_seen}, 8'h00);
        chk("R8 start one cycle", {7'b0, start_after}, 8'h00);
        do_read(8'h18, 8'h00, "R4 addr 18 bit0");

        // R9 result capture and hold
        meas(1'b1);
        chk("R9 result loaded", {7'b0, cca_status}, 8'h01);
        meas(1'b0);
        chk("R9 done without request ignored", {7'b0, cca_status}, 8'h01);
        do_write(8'h18, 8'h01);
        chk("R8 second start", {7'b0, start_seen}, 8'h01);
        chk("R8 status cleared again", {7'b0, stat_seen}, 8'h00);
        repeat (5) @(negedge clk);
        chk("R9 low while pending", {7'b0, cca_status}, 8'h00);
        do_read(8'h18, 8'h01, "R4 addr 18 set");
        meas(1'b0);
        chk("R9 busy result", {7'b0, cca_status}, 8'h00);
        meas(1'b1);
        chk("R9 stale done ignored", {7'b0, cca_status}, 8'h00);

        // R5 constant region
        do_read(8'h20, 8'h07, "R5 channel map masked");
        do_read(8'h21, 8'h09, "R5 power level count");
        do_write(8'h21, 8'hFF);
        do_read(8'h21, 8'h09, "R5 count unchanged");
        do_write(8'h55, 8'hAA);
        do_read(8'h55, 8'h00, "R5 unused constant");
        do_write(8'h25, 8'h22);
        do_read(8'h05, 8'hA5, "R5 alias write no effect");

        // R6 vendor region
        do_write(8'h90, 8'h77);
        do_read(8'h90, 8'h00, "R6 vendor reads zero");
        do_write(8'h85, 8'h11);
        do_read(8'h05, 8'hA5, "R6 alias write no effect");
        do_write(8'hFF, 8'h12);
        do_read(8'hFF, 8'h00, "R6 top address");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) chk("R2 missing read data", 8'(exp_q.size()), 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 50000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule